// File: doc/BRIEF.md
# Ring Emitter Scan Sequencer

This block steps six infrared emitters placed around a ring through one short scan. A fast pulse-rate tick paces the scan. Each tick advances a step count. Each emitter turns on for exactly one step, so the emitters light one after another in a fixed angular order. During the scan the block raises a driver enable. On every scan tick it also sets a buzzer from the level of a receiver input.

When the circle is complete, the block clears its outputs and goes idle. It stays idle for a programmable number of slow ticks, which can cover minutes or hours. It then arms the next scan. In a system, the fast tick comes from a divided crystal clock and the slow tick comes from a timer overflow. The receiver input is the comparator output of the optical front end.

Top module: `ring_scan_seq`

## Requirements
- R1: After reset, all six emitter lines, the enable and the buzzer are low. The block is ready to scan, so the first pulse tick raises emitter line 0.
- R2: Each pulse tick that arrives while scanning adds one to a step count that starts at 0. The tick that brings the count to 7 ends the circle, and the count restarts from 0.
- R3: Emitter k toggles on every scan tick whose new step count lies in the range k < count <= k+2. Emitter k therefore goes high on the tick that makes the count k+1 and goes low on the tick that makes it k+2. At most one emitter is high at any time.
- R4: The bit positions of the emitter bus follow the ring order. Bits 0 to 5 map to 150, 210, 270, 330, 30 and 90 degrees.
- R5: The enable goes high with the first tick of a circle and stays high until the circle ends. Whenever an emitter is high, the enable is high.
- R6: On every scan tick before the last one, the buzzer takes the inverse of the receiver input: on for a low input, off for a high input. Between ticks, changes on the receiver input do not affect the buzzer.
- R7: On the tick that ends a circle, the emitters, the enable and the buzzer go low together, and the idle counter takes the value of the interval input.
- R8: While idle, pulse ticks have no effect. After the programmed number of slow ticks, the block is armed again, and the next pulse tick starts a new circle at emitter 0.
- R9: An interval value of zero skips the idle phase. The pulse tick after a circle ends starts the next circle.
- R10: Slow ticks that arrive during a scan have no effect on the scan.
- R11: The interval input is read only at the end of a circle. Changing it while idle does not alter the idle phase already in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pulse_tick | input | 1 | One-cycle pulse-rate strobe that paces the scan |
| slow_tick | input | 1 | One-cycle strobe that counts the idle interval |
| idle_len | input | 16 | Idle interval in slow ticks (0 means none) |
| rx_in | input | 1 | Receiver level (low means echo seen) |
| emit | output | 6 | Emitter lines in ring order, bit 0 at 150 degrees |
| drv_en | output | 1 | Emitter driver enable |
| buzz | output | 1 | Buzzer drive |

## Verification
Every output is registered. Each result therefore appears at the first clock edge that sees the strobe high. The bench drives each strobe for one cycle starting at a falling edge and reads the outputs at the next falling edge. That is one cycle after the stimulus and before any further strobe. A return from idle is one cycle after the last slow tick, but it is visible only through the next pulse tick. So the checks on idle length count slow ticks, and after each partial count they issue a pulse tick to confirm the emitters stay low. The receiver input is moved between ticks and sampled before the next tick, so the check on the buzzer hold is made at that point.

// File: rtl/ring_scan_seq.sv
module ring_scan_seq #(
  parameter int NUM_EMIT = 6,
  parameter int IDLE_W   = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pulse_tick,
  input  logic                slow_tick,
  input  logic [IDLE_W-1:0]   idle_len,
  input  logic                rx_in,
  output logic [NUM_EMIT-1:0] emit,
  output logic                drv_en,
  output logic                buzz
);
  localparam int STEP_WRAP = NUM_EMIT + 1;
  localparam int STEP_W    = $clog2(STEP_WRAP + 1);

  typedef enum logic {ST_SCAN, ST_IDLE} st_t;

  st_t                 state;
  logic [STEP_W-1:0]   step;
  logic [STEP_W-1:0]   step_nx;
  logic [IDLE_W-1:0]   idle_cnt;
  logic [NUM_EMIT-1:0] flip;
  logic                scan_tick;
  logic                wrap;

  assign step_nx   = step + 1'b1;
  assign scan_tick = pulse_tick && (state == ST_SCAN);
  assign wrap      = (step_nx == STEP_W'(STEP_WRAP));

  for (genvar k = 0; k < NUM_EMIT; k++) begin : g_win
    assign flip[k] = (int'(step_nx) > k) && (int'(step_nx) <= k + 2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_SCAN;
      step     <= '0;
      idle_cnt <= '0;
      emit     <= '0;
      drv_en   <= 1'b0;
      buzz     <= 1'b0;
    end else if (scan_tick) begin
      if (wrap) begin
        step     <= '0;
        emit     <= '0;
        drv_en   <= 1'b0;
        buzz     <= 1'b0;
        idle_cnt <= idle_len;
        if (idle_len != '0) state <= ST_IDLE;
      end else begin
        step   <= step_nx;
        emit   <= emit ^ flip;
        drv_en <= 1'b1;
        buzz   <= ~rx_in;
      end
    end else if (state == ST_IDLE && slow_tick) begin
      idle_cnt <= idle_cnt - 1'b1;
      if (idle_cnt == IDLE_W'(1)) state <= ST_SCAN;
    end
  end

  AST_ONE_EMITTER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(emit)); // R3
  AST_EN_WITH_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (|emit) |-> drv_en); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> (emit == '0 && !drv_en && !buzz)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !slow_tick) |=> $stable(idle_cnt)); // R11
  AST_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && slow_tick && idle_cnt == IDLE_W'(1)) |=> (state == ST_SCAN)); // R8
  AST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_tick && wrap && idle_len != '0) |=> (state == ST_IDLE && idle_cnt == $past(idle_len))); // R7
  AST_SLOW_NO_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SCAN && !pulse_tick) |=> ($stable(emit) && $stable(step))); // R10
endmodule

// File: tb/ring_scan_seq_test.sv
module ring_scan_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pulse_tick = 1'b0;
  logic        slow_tick = 1'b0;
  logic [15:0] idle_len = 16'd0;
  logic        rx_in = 1'b1;
  logic [5:0]  emit;
  logic        drv_en;
  logic        buzz;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ring_scan_seq uut (
    .clk(clk), .rst_n(rst_n), .pulse_tick(pulse_tick), .slow_tick(slow_tick),
    .idle_len(idle_len), .rx_in(rx_in), .emit(emit), .drv_en(drv_en), .buzz(buzz)
  );

  task automatic check(input string req, input logic [7:0] exp);
    logic [7:0] act;
    act = {emit, drv_en, buzz};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: {emit,en,buzz} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic pulse(input logic rx);
    @(negedge clk);
    rx_in = rx;
    pulse_tick = 1'b1;
    @(negedge clk);
    pulse_tick = 1'b0;
  endtask

  task automatic slow();
    @(negedge clk);
    slow_tick = 1'b1;
    @(negedge clk);
    slow_tick = 1'b0;
  endtask

  function automatic logic [7:0] exp_step(input int n, input logic rx);
    if (n >= 1 && n <= 6) return {6'(1 << (n - 1)), 1'b1, ~rx};
    return 8'b0;
  endfunction

  task automatic t_reset();
    check("R1 reset", 8'b0);
  endtask

  task automatic t_full_circle(input logic [15:0] len);
    idle_len = len;
    for (int n = 1; n <= 7; n++) begin
      logic r;
      r = n[0];
      pulse(r);
      if (n == 7) check("R2 R7 circle end clears", exp_step(n, r));
      else if (n == 1) check("R4 R5 first emitter 150deg", exp_step(n, r));
      else check("R3 R6 step window", exp_step(n, r));
    end
  endtask

  task automatic t_idle_count();
    idle_len = 16'd3;
    t_full_circle(16'd3);
    pulse(1'b0);
    check("R8 pulse ignored while idle", 8'b0);
    slow();
    slow();
    idle_len = 16'd0;
    pulse(1'b0);
    check("R11 interval change while idle ignored", 8'b0);
    slow();
    pulse(1'b0);
    check("R8 rescan after interval", 8'b00000111);
  endtask

  task automatic t_rx_hold();
    rx_in = 1'b1;
    #1;
    check("R6 buzz holds between ticks", 8'b00000111);
    pulse(1'b1);
    check("R6 buzz off for high rx", 8'b00001010);
  endtask

  task automatic t_slow_in_scan();
    slow();
    slow();
    check("R10 slow tick during scan", 8'b00001010);
    for (int n = 3; n <= 7; n++) begin
      pulse(1'b0);
      check("R10 scan continues", exp_step(n, 1'b0));
    end
  endtask

  task automatic t_zero_interval();
    pulse(1'b0);
    check("R9 zero interval restarts at once", exp_step(1, 1'b0));
    for (int n = 2; n <= 7; n++) pulse(1'b1);
    check("R9 circle end with zero interval", 8'b0);
  endtask

  task automatic t_interval_one();
    idle_len = 16'd1;
    for (int n = 1; n <= 7; n++) pulse(1'b1);
    pulse(1'b0);
    check("R8 idle of one slow tick still blocks", 8'b0);
    slow();
    pulse(1'b1);
    check("R8 wake after one slow tick", exp_step(1, 1'b1));
  endtask

  initial begin
    #2000000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_circle(16'd0);
    t_idle_count();
    t_rx_hold();
    t_slow_in_scan();
    t_zero_interval();
    t_interval_one();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule